// File: doc/BRIEF.md
# Dual-Accumulator 8-bit Binary ALU

This block executes the two-operand arithmetic and logic group of a small 8-bit processor. It holds two accumulators and a four-bit condition-code register (negative, zero, overflow, carry). Each cycle in which `valid_i` is high, it decodes `opcode_i`, combines the selected accumulator with `operand_i`, and on the next rising clock edge writes the result back and updates the flags. The surrounding pipeline has already fetched the operand and resolved the address.

Opcode bit 7 marks the binary group, bit 6 picks the accumulator, bits 5:4 carry the addressing mode, and bits 3:0 pick the operation. A store places the selected accumulator on `store_data_o` for the memory side in the same cycle. Codes outside the supported set are reported and leave all state unchanged.

Top module: `dual_acc_alu`

## Requirements
- R1: Load (bits 3:0 = 6) writes `operand_i` into accumulator A when bit 6 is 0 and into B when bit 6 is 1. The other accumulator keeps its value. N = result bit 7, Z = (result == 0), V = 0, and C is kept. `flags_o` is {N, Z, V, C}, with N in bit 3 and C in bit 0.
- R2: Add (B) and add-with-carry (9) write acc + operand (+ C for 9). C is the carry out of bit 7, V is set on signed overflow, and N and Z follow the result.
- R3: Subtract (0) and subtract-with-carry (2) write acc − operand (− C for 2). C is set when the unsigned subtrahend plus the borrow exceeds the accumulator, V is set on signed overflow, and N and Z follow the result.
- R4: Compare (1) sets N, Z, V and C exactly as subtract does and leaves both accumulators unchanged.
- R5: AND (4), exclusive-OR (8) and inclusive-OR (A) write the bitwise result, clear V and keep C.
- R6: Bit test (5) sets N and Z from acc AND operand, clears V, keeps C, and writes no accumulator.
- R7: Store (7) with mode bits not 00 raises `store_en_o` and drives the selected accumulator on `store_data_o` in the same cycle. It sets N and Z from that value, clears V, keeps C, and changes no accumulator.
- R8: Store with immediate mode (bits 5:4 = 00, opcodes 0x87 and 0xC7) raises `illegal_o`, keeps `store_en_o` low, and changes no accumulator or flag.
- R9: Opcodes with bit 7 clear, or with bits 3:0 equal to 3 or C to F, raise `unsupported_o` and change no state.
- R10: Bits 5:4 have no effect on the result of any supported operation other than the R8 case.
- R11: Reset (`rst_ni` low) clears both accumulators and all flags. While `valid_i` is low, no state changes and `illegal_o`, `unsupported_o` and `store_en_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| opcode_i | input | 8 | Opcode |
| operand_i | input | 8 | Fetched operand |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| flags_o | output | 4 | {N, Z, V, C} |
| store_en_o | output | 1 | Store data valid this cycle |
| store_data_o | output | 8 | Accumulator value for a store |
| illegal_o | output | 1 | Undefined store-immediate opcode |
| unsupported_o | output | 1 | Opcode outside this group |

## Verification
The bench targets the carry chain. It pushes add-with-carry and subtract-with-carry through carry-in 0 and 1 at the 0x7F/0x80 and 0x00/0xFF boundaries. A design that ignored the incoming carry, or inverted the borrow sense, would produce results and C flags one count off. It also checks that compare and bit test leave the accumulators intact, and that logic operations preserve C. A design that wrote back on those codes, or cleared C, would corrupt the following add-with-carry. Finally, it runs store-immediate and out-of-group codes between known states; any state that leaks through would show up at the accumulator and flag outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OP_SUB = 4'h0;
  localparam logic [3:0] OP_CMP = 4'h1;
  localparam logic [3:0] OP_SBC = 4'h2;
  localparam logic [3:0] OP_AND = 4'h4;
  localparam logic [3:0] OP_BIT = 4'h5;
  localparam logic [3:0] OP_LD  = 4'h6;
  localparam logic [3:0] OP_ST  = 4'h7;
  localparam logic [3:0] OP_EOR = 4'h8;
  localparam logic [3:0] OP_ADC = 4'h9;
  localparam logic [3:0] OP_ORA = 4'hA;
  localparam logic [3:0] OP_ADD = 4'hB;

  localparam logic [1:0] MODE_IMM = 2'b00;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    logic       unsup;
    logic       illegal;
    logic       sel_b;
    logic       wr_acc;
    logic       is_store;
    logic [3:0] op;
  } dec_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);
  logic [3:0] nib;
  assign nib = opcode_i[3:0];

  always_comb begin
    dec_o          = '0;
    dec_o.op       = nib;
    dec_o.sel_b    = opcode_i[6];
    dec_o.is_store = (nib == OP_ST);
    unique case (nib)
      OP_SUB, OP_SBC, OP_AND, OP_LD,
      OP_EOR, OP_ADC, OP_ORA, OP_ADD: dec_o.wr_acc = 1'b1;
      OP_CMP, OP_BIT, OP_ST:          dec_o.wr_acc = 1'b0;
      default: begin
        dec_o.wr_acc = 1'b0;
        dec_o.unsup  = 1'b1;
      end
    endcase
    if (!opcode_i[7]) dec_o.unsup = 1'b1;
    dec_o.illegal = !dec_o.unsup && dec_o.is_store && (opcode_i[5:4] == MODE_IMM);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_a_i,
  input  logic [DW-1:0] acc_b_i,
  input  logic          sel_b_i,
  input  logic [DW-1:0] operand_i,
  input  logic [3:0]    op_i,
  input  flags_t        flags_i,
  output logic [DW-1:0] result_o,
  output flags_t        flags_o
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] a, b;
  logic [DW:0]   wide;
  logic [DW:0]   cin_w;
  logic          arith, is_sub;

  assign a     = sel_b_i ? acc_b_i : acc_a_i;
  assign b     = operand_i;
  assign cin_w = {{DW{1'b0}}, flags_i.c};

  always_comb begin
    wide   = '0;
    arith  = 1'b0;
    is_sub = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin wide = {1'b0, a} - {1'b0, b};          arith = 1'b1; is_sub = 1'b1; end
      OP_SBC:         begin wide = {1'b0, a} - {1'b0, b} - cin_w;  arith = 1'b1; is_sub = 1'b1; end
      OP_ADD:         begin wide = {1'b0, a} + {1'b0, b};          arith = 1'b1; end
      OP_ADC:         begin wide = {1'b0, a} + {1'b0, b} + cin_w;  arith = 1'b1; end
      OP_AND, OP_BIT: wide = {1'b0, a & b};
      OP_EOR:         wide = {1'b0, a ^ b};
      OP_ORA:         wide = {1'b0, a | b};
      OP_LD:          wide = {1'b0, b};
      OP_ST:          wide = {1'b0, a};
      default:        wide = '0;
    endcase
  end

  assign result_o = wide[DW-1:0];

  always_comb begin
    flags_o.n = result_o[MSB];
    flags_o.z = (result_o == '0);
    flags_o.c = arith ? wide[DW] : flags_i.c;
    if (!arith)      flags_o.v = 1'b0;
    else if (is_sub) flags_o.v = (a[MSB] != b[MSB]) && (result_o[MSB] != a[MSB]);
    else             flags_o.v = (a[MSB] == b[MSB]) && (result_o[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_regs.sv
module alu_regs
  import alu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NACC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NACC-1:0]          acc_we_i,
  input  logic                     flag_we_i,
  input  logic [DW-1:0]            wdata_i,
  input  flags_t                   flags_i,
  output logic [NACC-1:0][DW-1:0]  acc_o,
  output flags_t                   flags_o
);
  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          acc_o[g] <= '0;
      else if (acc_we_i[g]) acc_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_o <= '0;
    else if (flag_we_i) flags_o <= flags_i;
  end

  // R1: at most one accumulator written per operation
  a_r1_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_we_i));
endmodule

// File: rtl/dual_acc_alu.sv
module dual_acc_alu
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [7:0]    opcode_i,
  input  logic [DW-1:0] operand_i,
  output logic [DW-1:0] acc_a_o,
  output logic [DW-1:0] acc_b_o,
  output logic [3:0]    flags_o,
  output logic          store_en_o,
  output logic [DW-1:0] store_data_o,
  output logic          illegal_o,
  output logic          unsupported_o
);
  localparam int NACC = 2;

  dec_t                     dec;
  flags_t                   flags_q, flags_nx;
  logic [DW-1:0]            result;
  logic [NACC-1:0][DW-1:0]  acc_q;
  logic [NACC-1:0]          acc_we;
  logic                     commit;

  alu_decode u_decode (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  alu_core #(.DW(DW)) u_core (
    .acc_a_i   (acc_q[0]),
    .acc_b_i   (acc_q[1]),
    .sel_b_i   (dec.sel_b),
    .operand_i (operand_i),
    .op_i      (dec.op),
    .flags_i   (flags_q),
    .result_o  (result),
    .flags_o   (flags_nx)
  );

  assign commit = valid_i && !dec.unsup && !dec.illegal;
  assign acc_we = {commit && dec.wr_acc && dec.sel_b, commit && dec.wr_acc && !dec.sel_b};

  alu_regs #(.DW(DW), .NACC(NACC)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_we_i  (acc_we),
    .flag_we_i (commit),
    .wdata_i   (result),
    .flags_i   (flags_nx),
    .acc_o     (acc_q),
    .flags_o   (flags_q)
  );

  assign acc_a_o       = acc_q[0];
  assign acc_b_o       = acc_q[1];
  assign flags_o       = flags_q;
  assign store_en_o    = commit && dec.is_store;
  assign store_data_o  = result;
  assign illegal_o     = valid_i && dec.illegal;
  assign unsupported_o = valid_i && dec.unsup;

  a_r8_illegal_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(flags_o));

  a_r9_unsup_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(flags_o));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(flags_o));

  a_r4_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7] && opcode_i[3:0] == OP_CMP) |=> $stable(acc_a_o) && $stable(acc_b_o));

  a_r5_logic_keeps_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7] && (opcode_i[3:0] == OP_AND || opcode_i[3:0] == OP_EOR ||
     opcode_i[3:0] == OP_ORA)) |=> $stable(flags_o[0]) && !flags_o[1]);

  a_r7_store_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_en_o |-> store_data_o == (opcode_i[6] ? acc_b_o : acc_a_o));

  a_r8_no_store_when_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !store_en_o && !unsupported_o);
endmodule

// File: tb/dual_acc_alu_bench.sv
module dual_acc_alu_bench;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [7:0]    opcode_i = '0;
  logic [DW-1:0] operand_i = '0;
  logic [DW-1:0] acc_a_o, acc_b_o, store_data_o;
  logic [3:0]    flags_o;
  logic          store_en_o, illegal_o, unsupported_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] ra = '0, rb = '0;
  logic [3:0] rf = '0;

  always #5 clk_i = ~clk_i;

  dual_acc_alu #(.DW(DW)) u_dual_acc_alu (.*);

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [7:0] op);
    case (op[3:0])
      4'h6:       return "R1";
      4'h9, 4'hB: return "R2";
      4'h0, 4'h2: return "R3";
      4'h1:       return "R4";
      4'h5:       return "R6";
      4'h7:       return "R7";
      default:    return "R5";
    endcase
  endfunction

  task automatic run_op(logic [7:0] op, logic [7:0] opd, string tag = "");
    logic [3:0] nib;
    logic [7:0] a, r;
    logic       unsup, ill, wr, arith, c, v;
    int         ua, ub, sa, sb, cin, ures, sres;
    string      req;
    nib   = op[3:0];
    a     = op[6] ? rb : ra;
    unsup = !op[7] || nib == 4'h3 || nib >= 4'hC;
    ill   = !unsup && nib == 4'h7 && op[5:4] == 2'b00;
    req   = unsup ? "R9" : ill ? "R8" : req_of(op);
    if (tag != "") req = tag;
    ua = a; ub = opd; sa = $signed(a); sb = $signed(opd); cin = rf[0];
    wr = 1'b0; arith = 1'b0; c = rf[0]; v = 1'b0; r = '0;
    case (nib)
      4'h0, 4'h1, 4'h2: begin
        if (nib != 4'h2) cin = 0;
        ures = ua - ub - cin; sres = sa - sb - cin;
        r = ures[7:0]; c = (ures < 0); v = (sres < -128 || sres > 127);
        wr = (nib != 4'h1);
      end
      4'h9, 4'hB: begin
        if (nib == 4'hB) cin = 0;
        ures = ua + ub + cin; sres = sa + sb + cin;
        r = ures[7:0]; c = (ures > 255); v = (sres < -128 || sres > 127);
        wr = 1'b1;
      end
      4'h4: begin r = a & opd; wr = 1'b1; end
      4'h5: r = a & opd;
      4'h6: begin r = opd; wr = 1'b1; end
      4'h7: r = a;
      4'h8: begin r = a ^ opd; wr = 1'b1; end
      4'hA: begin r = a | opd; wr = 1'b1; end
      default: r = '0;
    endcase
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = op; operand_i = opd;
    #2;
    chk(req, "illegal_o", 16'(illegal_o), 16'(ill));
    chk(req, "unsupported_o", 16'(unsupported_o), 16'(unsup));
    chk(req, "store_en_o", 16'(store_en_o), 16'(!unsup && !ill && nib == 4'h7));
    if (!unsup && !ill && nib == 4'h7) chk(req, "store_data_o", 16'(store_data_o), 16'(a));
    @(posedge clk_i); #2;
    if (!unsup && !ill) begin
      if (wr) begin
        if (op[6]) rb = r; else ra = r;
      end
      rf = {r[7], r == 8'h00, v, c};
    end
    chk(req, "acc_a_o", 16'(acc_a_o), 16'(ra));
    chk(req, "acc_b_o", 16'(acc_b_o), 16'(rb));
    chk(req, "flags_o", 16'(flags_o), 16'(rf));
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (2) @(negedge clk_i);
    #1;
    // R11 reset state
    chk("R11", "reset acc_a_o", 16'(acc_a_o), 16'h0);
    chk("R11", "reset acc_b_o", 16'(acc_b_o), 16'h0);
    chk("R11", "reset flags_o", 16'(flags_o), 16'h0);
    rst_ni = 1'b1;

    run_op(8'h86, 8'h80);          // R1 load A, negative
    run_op(8'hC6, 8'h00);          // R1 load B, zero
    run_op(8'h86, 8'h7F);
    run_op(8'h8B, 8'h01);          // R2 signed overflow 7F+01
    run_op(8'h86, 8'hFF);
    run_op(8'h8B, 8'h01);          // R2 carry out, zero result
    run_op(8'h89, 8'h7F);          // R2 add with carry in set
    run_op(8'hC6, 8'h00);
    run_op(8'hC0, 8'h01);          // R3 borrow 00-01
    run_op(8'hC2, 8'h00);          // R3 subtract borrow in
    run_op(8'h86, 8'h80);
    run_op(8'h80, 8'h01);          // R3 signed overflow 80-01
    run_op(8'h81, 8'h7F);          // R4 compare, no write
    run_op(8'hD1, 8'hFE);          // R4 compare equal on B
    run_op(8'h8B, 8'hFF);          // set C
    run_op(8'h84, 8'h0F);          // R5 AND keeps C
    run_op(8'hC8, 8'hAA);          // R5 XOR on B
    run_op(8'h8A, 8'h80);          // R5 OR
    run_op(8'h85, 8'h00);          // R6 bit test zero
    run_op(8'h97, 8'h00);          // R7 store A direct
    run_op(8'hF7, 8'h00);          // R7 store B extended
    run_op(8'h87, 8'h12);          // R8 store immediate A
    run_op(8'hC7, 8'h34);          // R8 store immediate B
    run_op(8'h83, 8'h55);          // R9 low nibble 3
    run_op(8'hCC, 8'h55);          // R9 low nibble C
    run_op(8'hFF, 8'h55);          // R9 low nibble F
    run_op(8'h46, 8'h55);          // R9 bit 7 clear
    run_op(8'h96, 8'h3C, "R10");   // R10 direct-mode load
    run_op(8'hBB, 8'h44, "R10");   // R10 extended-mode add
    run_op(8'hEA, 8'h01, "R10");   // R10 indexed-mode OR

    // R11 idle: valid low holds state
    @(negedge clk_i);
    valid_i = 1'b0; opcode_i = 8'h86; operand_i = 8'h99;
    repeat (2) @(posedge clk_i);
    #2;
    chk("R11", "idle acc_a_o", 16'(acc_a_o), 16'(ra));
    chk("R11", "idle acc_b_o", 16'(acc_b_o), 16'(rb));
    chk("R11", "idle flags_o", 16'(flags_o), 16'(rf));
    chk("R11", "idle unsupported_o", 16'(unsupported_o | illegal_o | store_en_o), 16'h0);

    for (int i = 0; i < 500; i++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if ($urandom_range(0, 7) != 0) op[7] = 1'b1;
      run_op(op, 8'($urandom));
    end

    @(negedge clk_i);
    valid_i = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule